// File: doc/BRIEF.md
# Link Request Receiver and Pending-Request Tracker

This block belongs to the physical layer of a serial-bus node. Each clock cycle it samples the one-bit request line driven by the link controller. It recognises a start bit and decodes a three-bit request code. It then gathers whatever payload that code carries and checks the stop bit. Register reads and writes come out as one-cycle strobes with their address and data. An acceleration-control request updates a held enable bit that the arbitration logic reads.

Bus requests (immediate, isochronous, priority, fair) are not passed on as pulses. They are kept as pending flags whose lifetime follows bus events. Fair and priority requests are dropped when a receive operation begins. The exception is a receive of an acknowledge packet while acceleration is enabled. An isochronous request survives receives and is cleared only by its own grant, a subaction gap or a bus request event. An immediate request waits for its own grant. Malformed transfers are discarded and reported by a single-cycle error pulse.

Top module: `lreq_tracker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, every output is 0.
- R2: A transfer on `lreq_in` has the following layout:
  - a start bit of 1;
  - a three-bit request code, most significant bit first;
  - the payload, most significant bit first;
  - a stop bit of 0.

  Codes: 000 immediate, 001 isochronous, 010 priority and 011 fair carry no payload. 100 read carries a 4-bit address. 101 write carries a 4-bit address and then 8-bit data. 110 acceleration control carries 1 bit. 111 is reserved. The effect of a transfer is visible in the cycle after the cycle that carries its stop bit.
- R3: A write pulses `reg_wr_stb` for one cycle, with `reg_addr` and `reg_wdata` set to the transferred address and data. Both hold until the next read or write.
- R4: A read pulses `reg_rd_stb` for one cycle, with `reg_addr` set to the transferred address and `reg_wdata` set to 0. `reg_rd_stb` and `reg_wr_stb` are never high together.
- R5: `accel_en` takes the payload bit of each acceleration-control request and holds it otherwise. It resets to 0.
- R6: Priority and fair requests set `pend_pri` and `pend_fair`. A cycle with `rx_start` high clears both flags, and also suppresses a priority or fair request that is in transfer during or after that cycle. This does not apply when `accel_en` and `rx_is_ack` are both high, in which case the flags are kept.
- R7: An isochronous request sets `pend_iso`. The flag clears only on a grant of code 01, on `sub_gap`, or on `bus_req_evt`. `rx_start` has no effect on it.
- R8: A reserved code, or a stop bit of 1, discards the transfer and pulses `frame_err` for one cycle. For a reserved code the pulse follows the cycle of the last code bit; for a bad stop bit it follows the stop-bit cycle. No other output changes.
- R9: An immediate request sets `pend_imm`. The flag clears only when a grant of code 00 is issued.
- R10: `grant_valid` with `grant_kind` clears the flag of that code: 00 immediate, 01 isochronous, 10 priority, 11 fair. A request completing in the same cycle as a grant, gap or bus request event still sets its flag. A cancelling `rx_start` takes precedence over a priority or fair request completing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, request line sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_in | input | 1 | Serial request line from the link |
| rx_start | input | 1 | A receive operation begins this cycle |
| rx_is_ack | input | 1 | The packet being received is an 8-bit acknowledge |
| grant_valid | input | 1 | Arbitration won, grant issued to the link |
| grant_kind | input | 2 | Request code the grant answers |
| sub_gap | input | 1 | Subaction gap detected |
| bus_req_evt | input | 1 | Bus request event |
| reg_rd_stb | output | 1 | Register read strobe |
| reg_wr_stb | output | 1 | Register write strobe |
| reg_addr | output | 4 | Register address of the last read or write |
| reg_wdata | output | 8 | Write data of the last write, 0 after a read |
| accel_en | output | 1 | Acceleration enable |
| frame_err | output | 1 | One-cycle malformed-transfer pulse |
| pend_imm | output | 1 | Immediate request pending |
| pend_iso | output | 1 | Isochronous request pending |
| pend_pri | output | 1 | Priority request pending |
| pend_fair | output | 1 | Fair request pending |

## Verification
The bench sends every request code, with payloads that have alternating and edge-valued bits, so that a swapped field or a reversed bit order shows up as a wrong address or data. Receive starts are sent three ways:
- plain;
- marked as acknowledge with acceleration off;
- marked as acknowledge with acceleration on.

Together these separate cancellation from the acceleration exception. The isochronous flag is cleared once by each of its three events, and a receive start is shown to leave it alone. A receive start during a fair transfer, and reserved or bad-stop transfers, exercise the discard paths.

// File: rtl/lreq_pkg.sv
// Shared types for the link request receiver.
// Assumes a 3-bit request code whose values 0..3 match the grant codes.
package lreq_pkg;
    typedef enum logic [2:0] {
        RQ_IMM  = 3'd0,
        RQ_ISO  = 3'd1,
        RQ_PRI  = 3'd2,
        RQ_FAIR = 3'd3,
        RQ_RD   = 3'd4,
        RQ_WR   = 3'd5,
        RQ_ACC  = 3'd6,
        RQ_RSV  = 3'd7
    } rq_kind_t;

    localparam int NUM_BUS_REQ = 4;
endpackage

// File: rtl/lreq_deser.sv
// Serial request deserializer.
// Detects a start bit, shifts in the 3-bit code and its payload, and checks
// the stop bit. done/bad are combinational in the stop (or last code) cycle.
// Assumes the line idles low between transfers.
module lreq_deser
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lreq_in,
    output logic                     busy,
    output logic                     done,
    output logic                     bad,
    output rq_kind_t                 kind,
    output logic [ADDR_W+DATA_W-1:0] payload
);
    localparam int PW = ADDR_W + DATA_W;
    localparam int CW = $clog2(PW + 1);

    typedef enum logic [1:0] {S_IDLE, S_TYPE, S_PAY, S_STOP} st_t;

    st_t            st_q;
    logic [CW-1:0]  cnt_q;
    rq_kind_t       kind_q;
    logic [PW-1:0]  sh_q;
    rq_kind_t       kind_nx;

    // Payload length for each request code
    function automatic int plen_of(rq_kind_t k);
        case (k)
            RQ_RD:   return ADDR_W;
            RQ_WR:   return PW;
            RQ_ACC:  return 1;
            default: return 0;
        endcase
    endfunction

    // Code value including the bit on the line this cycle
    assign kind_nx = rq_kind_t'({kind_q[1:0], lreq_in});

    // Framing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            kind_q <= RQ_IMM;
            sh_q   <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (lreq_in) begin
                        st_q  <= S_TYPE;
                        cnt_q <= '0;
                        sh_q  <= '0;
                    end
                end
                S_TYPE: begin
                    kind_q <= kind_nx;
                    cnt_q  <= cnt_q + CW'(1);
                    if (cnt_q == CW'(2)) begin
                        cnt_q <= '0;
                        if (kind_nx == RQ_RSV)
                            st_q <= S_IDLE;
                        else if (plen_of(kind_nx) == 0)
                            st_q <= S_STOP;
                        else
                            st_q <= S_PAY;
                    end
                end
                S_PAY: begin
                    sh_q  <= {sh_q[PW-2:0], lreq_in};
                    cnt_q <= cnt_q + CW'(1);
                    if (int'(cnt_q) == plen_of(kind_q) - 1)
                        st_q <= S_STOP;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Completion and error qualifiers
    always_comb begin
        busy    = (st_q != S_IDLE);
        done    = (st_q == S_STOP) && !lreq_in;
        bad     = ((st_q == S_STOP) && lreq_in) ||
                  ((st_q == S_TYPE) && (cnt_q == CW'(2)) && (kind_nx == RQ_RSV));
        kind    = kind_q;
        payload = sh_q;
    end
endmodule

// File: rtl/lreq_pend.sv
// Pending bus-request flags.
// One flag per bus request code (0 imm, 1 iso, 2 pri, 3 fair). Priority and
// fair flags are cancellable by a receive start unless it is an acknowledge
// while acceleration is on. The isochronous flag also clears on gap and bus
// request events. Set wins over grant/gap clears; cancel wins over set.
module lreq_pend
    import lreq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  rq_kind_t               kind,
    input  logic                   busy,
    input  logic                   rx_start,
    input  logic                   rx_is_ack,
    input  logic                   accel_en,
    input  logic                   grant_valid,
    input  logic [1:0]             grant_kind,
    input  logic                   sub_gap,
    input  logic                   bus_req_evt,
    output logic [NUM_BUS_REQ-1:0] pend
);
    logic cancel;
    logic kill_q;

    assign cancel = rx_start && !(accel_en && rx_is_ack);

    // Remember a cancel that arrived while a transfer was in progress
    always_ff @(posedge clk) begin
        if (!rst_n)
            kill_q <= 1'b0;
        else if (!busy)
            kill_q <= 1'b0;
        else if (cancel)
            kill_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_BUS_REQ; i++) begin : g_flag
        localparam bit CANCELLABLE = (i >= 2);
        localparam bit EVT_CLEARED = (i == 1);
        logic hit_set;
        logic hit_clr;
        logic flag_q;

        assign hit_set = done && (kind == rq_kind_t'(3'(i))) &&
                         !(CANCELLABLE && (cancel || kill_q));
        assign hit_clr = (grant_valid && (grant_kind == 2'(i))) ||
                         (CANCELLABLE && cancel) ||
                         (EVT_CLEARED && (sub_gap || bus_req_evt));

        // Flag update: set first, then clear, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (hit_set)
                flag_q <= 1'b1;
            else if (hit_clr)
                flag_q <= 1'b0;
        end

        assign pend[i] = flag_q;
    end
endmodule

// File: rtl/lreq_tracker.sv
// Link request receiver and pending-request tracker (top).
// Decodes serial requests, issues register strobes, holds the acceleration
// enable, and tracks pending bus requests. All outputs are registered.
module lreq_tracker
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_in,
    input  logic              rx_start,
    input  logic              rx_is_ack,
    input  logic              grant_valid,
    input  logic [1:0]        grant_kind,
    input  logic              sub_gap,
    input  logic              bus_req_evt,
    output logic              reg_rd_stb,
    output logic              reg_wr_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              accel_en,
    output logic              frame_err,
    output logic              pend_imm,
    output logic              pend_iso,
    output logic              pend_pri,
    output logic              pend_fair
);
    localparam int PW = ADDR_W + DATA_W;

    logic                   busy;
    logic                   done;
    logic                   bad;
    rq_kind_t               kind;
    logic [PW-1:0]          payload;
    logic [NUM_BUS_REQ-1:0] pend;

    lreq_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .lreq_in (lreq_in),
        .busy    (busy),
        .done    (done),
        .bad     (bad),
        .kind    (kind),
        .payload (payload)
    );

    lreq_pend u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .kind        (kind),
        .busy        (busy),
        .rx_start    (rx_start),
        .rx_is_ack   (rx_is_ack),
        .accel_en    (accel_en),
        .grant_valid (grant_valid),
        .grant_kind  (grant_kind),
        .sub_gap     (sub_gap),
        .bus_req_evt (bus_req_evt),
        .pend        (pend)
    );

    // Register strobes, address/data, acceleration enable and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_stb <= 1'b0;
            reg_wr_stb <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            accel_en   <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            reg_rd_stb <= done && (kind == RQ_RD);
            reg_wr_stb <= done && (kind == RQ_WR);
            frame_err  <= bad;
            if (done && (kind == RQ_RD)) begin
                reg_addr  <= payload[ADDR_W-1:0];
                reg_wdata <= '0;
            end
            if (done && (kind == RQ_WR)) begin
                reg_addr  <= payload[PW-1:DATA_W];
                reg_wdata <= payload[DATA_W-1:0];
            end
            if (done && (kind == RQ_ACC))
                accel_en <= payload[0];
        end
    end

    assign pend_imm  = pend[0];
    assign pend_iso  = pend[1];
    assign pend_pri  = pend[2];
    assign pend_fair = pend[3];
endmodule

// File: rtl/lreq_tracker_chk.sv
// Protocol checker for lreq_tracker, attached with bind.
module lreq_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_start,
    input logic       rx_is_ack,
    input logic       grant_valid,
    input logic [1:0] grant_kind,
    input logic       sub_gap,
    input logic       bus_req_evt,
    input logic       reg_rd_stb,
    input logic       reg_wr_stb,
    input logic       accel_en,
    input logic       frame_err,
    input logic       pend_iso,
    input logic       pend_pri,
    input logic       pend_fair
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_stb && reg_wr_stb));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6
    fair_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_fair && rx_start && !(accel_en && rx_is_ack)) |=> !pend_fair);

    // R6
    pri_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_pri && rx_start && accel_en && rx_is_ack &&
         !(grant_valid && grant_kind == 2'd2)) |=> pend_pri);

    // R7
    iso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_iso && !(grant_valid && grant_kind == 2'd1) &&
         !sub_gap && !bus_req_evt) |=> pend_iso);
endmodule

bind lreq_tracker lreq_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_start    (rx_start),
    .rx_is_ack   (rx_is_ack),
    .grant_valid (grant_valid),
    .grant_kind  (grant_kind),
    .sub_gap     (sub_gap),
    .bus_req_evt (bus_req_evt),
    .reg_rd_stb  (reg_rd_stb),
    .reg_wr_stb  (reg_wr_stb),
    .accel_en    (accel_en),
    .frame_err   (frame_err),
    .pend_iso    (pend_iso),
    .pend_pri    (pend_pri),
    .pend_fair   (pend_fair)
);

// File: tb/test_lreq_tracker.sv
module test_lreq_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lreq_in = 1'b0;
    logic       rx_start = 1'b0;
    logic       rx_is_ack = 1'b0;
    logic       grant_valid = 1'b0;
    logic [1:0] grant_kind = 2'd0;
    logic       sub_gap = 1'b0;
    logic       bus_req_evt = 1'b0;
    logic       reg_rd_stb, reg_wr_stb, accel_en, frame_err;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       pend_imm, pend_iso, pend_pri, pend_fair;

    int errors = 0;
    int checks = 0;
    bit fin = 0;

    always #2 clk = ~clk;

    lreq_tracker i_lreq_tracker (.*);

    // ---------------- reference model ----------------
    bit       m_busy, m_kill, m_rd, m_wr, m_acc, m_err;
    bit       m_imm, m_iso, m_pri, m_fair;
    bit [3:0] m_addr;
    bit [7:0] m_data;
    bit       bits[$];
    int       m_tp;

    function automatic int mplen(int t);
        if (t == 4) return 4;
        if (t == 5) return 12;
        if (t == 6) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        int  done_k;
        bit  cancel;
        if (!rst_n) begin
            m_busy = 0; m_kill = 0; m_rd = 0; m_wr = 0; m_acc = 0; m_err = 0;
            m_imm = 0; m_iso = 0; m_pri = 0; m_fair = 0;
            m_addr = 0; m_data = 0; bits.delete(); m_tp = 0;
        end else begin
            m_rd = 0; m_wr = 0; m_err = 0; done_k = -1;
            cancel = rx_start && !(m_acc && rx_is_ack);
            if (!m_busy) begin
                if (lreq_in) begin
                    m_busy = 1; m_kill = 0; bits.delete();
                end
            end else begin
                if (cancel) m_kill = 1;
                bits.push_back(lreq_in);
                if (bits.size() == 3) begin
                    m_tp = int'(bits[0]) * 4 + int'(bits[1]) * 2 + int'(bits[2]);
                    if (m_tp == 7) begin
                        m_err = 1; m_busy = 0;
                    end
                end
                if (m_busy && bits.size() == 4 + mplen(m_tp)) begin
                    if (lreq_in) m_err = 1;
                    else done_k = m_tp;
                    m_busy = 0;
                end
            end
            if (grant_valid && grant_kind == 0) m_imm = 0;
            if ((grant_valid && grant_kind == 1) || sub_gap || bus_req_evt) m_iso = 0;
            if ((grant_valid && grant_kind == 2) || cancel) m_pri = 0;
            if ((grant_valid && grant_kind == 3) || cancel) m_fair = 0;
            case (done_k)
                0: m_imm = 1;
                1: m_iso = 1;
                2: if (!m_kill) m_pri = 1;
                3: if (!m_kill) m_fair = 1;
                4: begin
                    m_rd = 1; m_data = 0;
                    for (int i = 0; i < 4; i++) m_addr[3-i] = bits[3+i];
                end
                5: begin
                    m_wr = 1;
                    for (int i = 0; i < 4; i++) m_addr[3-i] = bits[3+i];
                    for (int i = 0; i < 8; i++) m_data[7-i] = bits[7+i];
                end
                6: m_acc = bits[3];
                default: ;
            endcase
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!fin && rst_n) begin
            chk("R2 R3 R4 strobes/addr/data",
                32'({reg_rd_stb, reg_wr_stb, reg_addr, reg_wdata}),
                32'({m_rd, m_wr, m_addr, m_data}));
            chk("R5 accel_en", 32'(accel_en), 32'(m_acc));
            chk("R8 frame_err", 32'(frame_err), 32'(m_err));
            chk("R9 R10 pend_imm", 32'(pend_imm), 32'(m_imm));
            chk("R7 R10 pend_iso", 32'(pend_iso), 32'(m_iso));
            chk("R6 R10 pend_pri/fair", 32'({pend_pri, pend_fair}), 32'({m_pri, m_fair}));
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input bit b);
        @(negedge clk);
        lreq_in = b;
    endtask

    // R2 layout: start 1, code MSB first, payload MSB first, stop
    task automatic send(input int t, input int nb, input int val, input bit stopb);
        put(1'b1);
        for (int i = 2; i >= 0; i--) put(t[i]);
        for (int i = nb - 1; i >= 0; i--) put(val[i]);
        put(stopb);
        put(1'b0);
        put(1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rx(input bit ack);
        @(negedge clk); rx_start = 1; rx_is_ack = ack;
        @(negedge clk); rx_start = 0; rx_is_ack = 0;
        idle(1);
    endtask

    task automatic grant(input int k);
        @(negedge clk); grant_valid = 1; grant_kind = 2'(k);
        @(negedge clk); grant_valid = 0;
        idle(1);
    endtask

    initial begin
        idle(3);
        // R1: outputs zero during reset
        chk("R1 reset", 32'({reg_rd_stb, reg_wr_stb, reg_addr, reg_wdata, accel_en,
                             frame_err, pend_imm, pend_iso, pend_pri, pend_fair}), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", 32'({reg_rd_stb, reg_wr_stb, accel_en, frame_err,
                                   pend_imm, pend_iso, pend_pri, pend_fair}), 32'd0);
        // R3, R4: register accesses with varied bit patterns
        send(5, 12, 12'hA5C, 1'b0);
        send(5, 12, 12'h1F0, 1'b0);
        send(4, 4, 4'h3, 1'b0);
        send(4, 4, 4'hC, 1'b0);
        // R9, R7, R6: set all four pending flags
        send(0, 0, 0, 1'b0);
        send(1, 0, 0, 1'b0);
        send(2, 0, 0, 1'b0);
        send(3, 0, 0, 1'b0);
        // R6, R7: plain receive cancels pri/fair, iso stays
        rx(1'b0);
        // R9, R10: imm grant clears imm
        grant(0);
        // R7: iso cleared by grant, gap and bus request event
        grant(1);
        send(1, 0, 0, 1'b0);
        @(negedge clk); sub_gap = 1; @(negedge clk); sub_gap = 0;
        send(1, 0, 0, 1'b0);
        @(negedge clk); bus_req_evt = 1; @(negedge clk); bus_req_evt = 0;
        // R6: ack receive with acceleration off still cancels
        send(2, 0, 0, 1'b0);
        rx(1'b1);
        // R5: acceleration on, ack receive keeps flags, non-ack cancels
        send(6, 1, 1, 1'b0);
        send(2, 0, 0, 1'b0);
        send(3, 0, 0, 1'b0);
        rx(1'b1);
        rx(1'b0);
        // R10: grants of pri/fair codes
        send(2, 0, 0, 1'b0);
        send(3, 0, 0, 1'b0);
        grant(2);
        grant(3);
        send(6, 1, 0, 1'b0);
        // R6: receive start during a fair transfer suppresses it
        put(1'b1); put(1'b0);
        rx_start = 1;
        put(1'b1);
        rx_start = 0;
        put(1'b1); put(1'b0); put(1'b0); idle(2);
        // R8: reserved code and bad stop bit
        send(7, 0, 0, 1'b0);
        send(5, 12, 12'h777, 1'b1);
        send(0, 0, 0, 1'b1);
        idle(4);
        fin = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!fin) begin
            fin = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule